// File: doc/BRIEF.md
# Debounced Input Port with Ready and Overrun Status

This block is a memory-mapped input peripheral for a bank of switches (ten inputs by default) or, built with other parameters, a bank of push keys. It presents two registers on a simple processor bus. The value register holds a filtered copy of the raw inputs. The status/control word holds a Ready flag, a sticky Overrun flag and an interrupt enable. The raw inputs are first synchronized to the clock. They are then accepted into the value register only once they have stayed unchanged for a programmable number of millisecond ticks, ten by default. A millisecond tick comes from a parameterized clock divider.

Software polls Ready or takes the interrupt request, which is high while both Ready and the enable are set. Reading the value register consumes the event and drops Ready. If a new filtered value arrives while the previous one was never read, Overrun records the loss. Overrun stays set until software writes a zero to its bit. Read data is combinational and is zero whenever this block is not the target of a read, so the read buses of several peripherals can be ORed together.

Top module: `debounce_port`

## Requirements
- R1: After reset the value register, the status/control word and `irq` are all zero.
- R2: A change on `rawIn` reaches the value register at exactly the 3 + CLKS_PER_MS*STABLE_MS-th rising edge after it is applied (two synchronizer edges, one restart edge, then STABLE_MS ticks of CLKS_PER_MS cycles). A change that lasts fewer cycles than that leaves the value register and Ready unchanged.
- R3: Ready is status bit 0. It is set on the edge that loads a new value, and cleared by a read of the value register. Bus writes to bit 0 have no effect.
- R4: Overrun is status bit 2. It is set when a new value loads while Ready is 1. Writing 0 to bit 2 clears it, and writing 1 leaves it unchanged.
- R5: The interrupt enable is status bit 8. Writing to the status word stores bit 8, and the stored value reads back.
- R6: `irq` is high exactly while Ready and the interrupt enable are both 1.
- R7: Bus writes to the value register leave its contents unchanged.
- R8: `busRdData` is zero unless `busValid` is high, `busWe` is low and the address matches one of the two registers. The value register reads zero-extended. Status bits other than 0, 2 and 8 read as zero. An access to any other address does not clear Ready.
- R9: If a read of the value register falls in the same cycle as a new value loading, Ready is 1 afterwards. The read in that cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | WIDTH | Unsynchronized switch or key levels |
| busValid | input | 1 | Bus access strobe for this cycle |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | 1 for a write, 0 for a read |
| busWrData | input | BUS_W | Write data |
| busRdData | output | BUS_W | Read data, zero when not selected |
| irq | output | 1 | Interrupt request, Ready AND enable |

## Verification
A new filtered value lands at the 3 + CLKS_PER_MS*STABLE_MS-th rising edge after the raw input changes. The bench counts edges from the falling edge where it drives `rawIn`. It shows the value not yet taken one edge before that point and taken at that edge. Status changes and `irq` follow one edge after the bus access or load that causes them. The bench reads the status word again at the next falling edge. Read data is combinational, so the bench samples it 1 ns after putting the address on the bus, within the same low clock phase. The same-cycle read and load case is timed so that the read strobe covers exactly the loading edge.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  localparam int READY_BIT = 0;
  localparam int OVR_BIT   = 2;
  localparam int IE_BIT    = 8;

  typedef struct packed {
    logic dataRd;
    logic ctrlRd;
    logic ctrlWr;
  } busStrobes_t;

endpackage

// File: rtl/dbp_sync.sv
module dbp_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dbp_tick.sv
module dbp_tick #(
  parameter int CLKS_PER_MS = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  output logic tick
);

  if (CLKS_PER_MS <= 1) begin : g_every
    assign tick = !clear;
  end else begin : g_div
    localparam int CW = $clog2(CLKS_PER_MS);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);
    logic [CW-1:0] cntQ;

    assign tick = !clear && (cntQ == LAST);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cntQ <= '0;
      else if (clear)      cntQ <= '0;
      else if (cntQ == LAST) cntQ <= '0;
      else                 cntQ <= cntQ + 1'b1;
    end
  end

endmodule

// File: rtl/dbp_filter.sv
module dbp_filter #(
  parameter int WIDTH     = 10,
  parameter int STABLE_MS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] syncIn,
  input  logic [WIDTH-1:0] heldVal,
  input  logic             tick,
  output logic             restart,
  output logic             commitNow,
  output logic [WIDTH-1:0] candidate
);

  localparam int CNT_W = (STABLE_MS > 1) ? $clog2(STABLE_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_MS - 1);

  logic [WIDTH-1:0] candQ;
  logic [CNT_W-1:0] msCntQ;

  assign candidate = candQ;
  assign restart   = (syncIn != candQ);
  assign commitNow = tick && !restart && (msCntQ == LAST) && (candQ != heldVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candQ  <= '0;
      msCntQ <= '0;
    end else if (restart) begin
      candQ  <= syncIn;
      msCntQ <= '0;
    end else if (tick && (msCntQ != LAST)) begin
      msCntQ <= msCntQ + 1'b1;
    end
  end

endmodule

// File: rtl/dbp_ctrl.sv
module dbp_ctrl
  import dbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 32'hF000_0014,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hF000_0114
) (
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobes_t       strobes
);

  logic hitData, hitCtrl;

  always_comb begin
    hitData        = busValid && (busAddr == DATA_ADDR);
    hitCtrl        = busValid && (busAddr == CTRL_ADDR);
    strobes.dataRd = hitData && !busWe;
    strobes.ctrlRd = hitCtrl && !busWe;
    strobes.ctrlWr = hitCtrl && busWe;
  end

endmodule

// File: rtl/dbp_datapath.sv
module dbp_datapath
  import dbp_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobes_t      strobes,
  input  logic [BUS_W-1:0] wrData,
  input  logic             commitNow,
  input  logic [WIDTH-1:0] candidate,
  output logic [BUS_W-1:0] rdData,
  output logic [WIDTH-1:0] dataHeld,
  output logic             readyBit,
  output logic             ovrBit,
  output logic             ieBit,
  output logic             irq
);

  logic [WIDTH-1:0] dataQ;
  logic readyQ, ovrQ, ieQ;
  logic [BUS_W-1:0] ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      readyQ <= 1'b0;
      ovrQ   <= 1'b0;
      ieQ    <= 1'b0;
    end else begin
      if (commitNow) dataQ <= candidate;

      if (commitNow)          readyQ <= 1'b1;
      else if (strobes.dataRd) readyQ <= 1'b0;

      if (commitNow && readyQ)                   ovrQ <= 1'b1;
      else if (strobes.ctrlWr && !wrData[OVR_BIT]) ovrQ <= 1'b0;

      if (strobes.ctrlWr) ieQ <= wrData[IE_BIT];
    end
  end

  always_comb begin
    ctrlWord            = '0;
    ctrlWord[READY_BIT] = readyQ;
    ctrlWord[OVR_BIT]   = ovrQ;
    ctrlWord[IE_BIT]    = ieQ;
    if (strobes.dataRd)      rdData = BUS_W'(dataQ);
    else if (strobes.ctrlRd) rdData = ctrlWord;
    else                     rdData = '0;
  end

  assign dataHeld = dataQ;
  assign readyBit = readyQ;
  assign ovrBit   = ovrQ;
  assign ieBit    = ieQ;
  assign irq      = readyQ && ieQ;

endmodule

// File: rtl/debounce_port.sv
module debounce_port
  import dbp_pkg::*;
#(
  parameter int WIDTH       = 10,
  parameter int ADDR_W      = 32,
  parameter int BUS_W       = 32,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 32'hF000_0014,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hF000_0114,
  parameter int CLKS_PER_MS = 250000,
  parameter int STABLE_MS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  rawIn,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic              irq
);

  busStrobes_t      strobes;
  logic [WIDTH-1:0] syncVal, candidate, dataHeld;
  logic             msTick, restart, commitNow;
  logic             readyBit, ovrBit, ieBit;
  logic             dataReadStb, ctrlWriteStb;

  assign dataReadStb  = strobes.dataRd;
  assign ctrlWriteStb = strobes.ctrlWr;

  dbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .syncOut(syncVal)
  );

  dbp_tick #(.CLKS_PER_MS(CLKS_PER_MS)) tick_i (
    .clk(clk), .rstN(rstN), .clear(restart), .tick(msTick)
  );

  dbp_filter #(.WIDTH(WIDTH), .STABLE_MS(STABLE_MS)) filt_i (
    .clk(clk), .rstN(rstN), .syncIn(syncVal), .heldVal(dataHeld),
    .tick(msTick), .restart(restart), .commitNow(commitNow),
    .candidate(candidate)
  );

  dbp_ctrl #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)) ctrl_i (
    .busValid(busValid), .busAddr(busAddr), .busWe(busWe), .strobes(strobes)
  );

  dbp_datapath #(.WIDTH(WIDTH), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .commitNow(commitNow), .candidate(candidate), .rdData(busRdData),
    .dataHeld(dataHeld), .readyBit(readyBit), .ovrBit(ovrBit),
    .ieBit(ieBit), .irq(irq)
  );

endmodule

// File: rtl/debounce_port_chk.sv
module debounce_port_chk #(
  parameter int WIDTH = 10,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic [BUS_W-1:0] busWrData,
  input logic [BUS_W-1:0] busRdData,
  input logic             irq,
  input logic             commitNow,
  input logic             dataReadStb,
  input logic             ctrlWriteStb,
  input logic [WIDTH-1:0] dataHeld,
  input logic             readyBit,
  input logic             ovrBit,
  input logic             ieBit
);

  p_load_sets_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    commitNow |=> readyBit);

  p_read_clears_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataReadStb && !commitNow) |=> !readyBit);

  p_change_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataReadStb && commitNow) |=> readyBit);

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (commitNow && readyBit) |=> ovrBit);

  p_ovr_w1_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovrBit && ctrlWriteStb && busWrData[2]) |=> ovrBit);

  p_ie_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWriteStb |=> (ieBit == $past(busWrData[8])));

  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !commitNow |=> $stable(dataHeld));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(commitNow) || $past(ctrlWriteStb)));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (busRdData == '0));

endmodule

bind debounce_port debounce_port_chk #(.WIDTH(WIDTH), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrData(busWrData),
  .busRdData(busRdData), .irq(irq), .commitNow(commitNow),
  .dataReadStb(dataReadStb), .ctrlWriteStb(ctrlWriteStb),
  .dataHeld(dataHeld), .readyBit(readyBit), .ovrBit(ovrBit), .ieBit(ieBit)
);

// File: tb/debounce_port_tb_top.sv
`timescale 1ns/1ps
module debounce_port_tb_top;

  localparam int W   = 10;
  localparam int CPM = 4;
  localparam int SMS = 10;
  localparam int LAT = 3 + CPM * SMS;
  localparam logic [31:0] DA = 32'hF000_0014;
  localparam logic [31:0] CA = 32'hF000_0114;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  rawIn = '0;
  logic          busValid = 1'b0;
  logic [31:0]   busAddr = '0;
  logic          busWe = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  debounce_port #(.WIDTH(W), .CLKS_PER_MS(CPM), .STABLE_MS(SMS)) dut_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .busValid(busValid),
    .busAddr(busAddr), .busWe(busWe), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [31:0] a, input logic we, output logic [31:0] v);
    busAddr = a; busWe = we; busWrData = '0; busValid = 1'b1;
    #1 v = busRdData;
    busValid = 1'b0; busWe = 1'b0;
  endtask

  task automatic busWrite(input logic [31:0] a, input logic [31:0] d);
    busAddr = a; busWe = 1'b1; busWrData = d; busValid = 1'b1;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [31:0] a, output logic [31:0] v);
    busAddr = a; busWe = 1'b0; busValid = 1'b1;
    #1 v = busRdData;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic settle(input logic [W-1:0] v);
    rawIn = v;
    repeat (LAT + 5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(CA, 1'b0, v); check("R1 ctrl after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    busRead(DA, v); check("R1 data after reset", v, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    rawIn = 10'h155;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    peek(CA, 1'b0, v); check("R2 not yet loaded one edge early", v, 32'h0);
    @(posedge clk); @(negedge clk);
    peek(CA, 1'b0, v); check("R3 ready set at load edge", v, 32'h1);
    busRead(DA, v); check("R2 loaded value", v, 32'h155);
    peek(CA, 1'b0, v); check("R3 data read clears ready", v, 32'h0);
  endtask

  task automatic t_glitch();
    logic [31:0] v;
    rawIn = 10'h154;
    repeat (20) @(posedge clk);
    @(negedge clk);
    rawIn = 10'h155;
    repeat (LAT + 20) @(posedge clk);
    @(negedge clk);
    peek(CA, 1'b0, v); check("R2 glitch leaves ready", v, 32'h0);
    busRead(DA, v); check("R2 glitch leaves data", v, 32'h155);
  endtask

  task automatic t_ready_write();
    logic [31:0] v;
    settle(10'h0AA);
    busWrite(CA, 32'h0);
    peek(CA, 1'b0, v); check("R3 write 0 to ready ignored", v, 32'h1);
    busRead(DA, v); check("R2 second value", v, 32'h0AA);
    busWrite(CA, 32'h1);
    peek(CA, 1'b0, v); check("R3 write 1 to ready ignored", v, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    settle(10'h001);
    peek(CA, 1'b0, v); check("R4 no overrun on first load", v, 32'h1);
    settle(10'h002);
    peek(CA, 1'b0, v); check("R4 overrun on unread load", v, 32'h5);
    busWrite(CA, 32'h4);
    peek(CA, 1'b0, v); check("R4 write 1 keeps overrun", v, 32'h5);
    busWrite(CA, 32'h0);
    peek(CA, 1'b0, v); check("R4 write 0 clears overrun", v, 32'h1);
    busRead(DA, v); check("R4 newest value kept", v, 32'h002);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    busWrite(CA, 32'h100);
    peek(CA, 1'b0, v); check("R5 enable reads back", v, 32'h100);
    check("R6 irq low without ready", {31'b0, irq}, 32'h0);
    settle(10'h003);
    check("R6 irq high with ready and enable", {31'b0, irq}, 32'h1);
    busRead(DA, v); check("R2 third value", v, 32'h003);
    check("R6 irq drops after read", {31'b0, irq}, 32'h0);
    busWrite(CA, 32'h0);
    peek(CA, 1'b0, v); check("R5 enable cleared", v, 32'h0);
  endtask

  task automatic t_data_write();
    logic [31:0] v;
    busWrite(DA, 32'h3FF);
    busRead(DA, v); check("R7 data write ignored", v, 32'h003);
    peek(CA, 1'b0, v); check("R7 data write leaves ready", v, 32'h0);
  endtask

  task automatic t_select();
    logic [31:0] v;
    settle(10'h004);
    peek(32'hF000_0018, 1'b0, v); check("R8 other address reads zero", v, 32'h0);
    busAddr = DA; busWe = 1'b0; busValid = 1'b0;
    #1 check("R8 idle bus reads zero", busRdData, 32'h0);
    peek(DA, 1'b1, v); check("R8 write cycle reads zero", v, 32'h0);
    busRead(32'hF000_0010, v);
    peek(CA, 1'b0, v); check("R8 foreign read keeps ready", v, 32'h1);
    busWrite(CA, 32'hFFFF_FFFF);
    peek(CA, 1'b0, v); check("R8 unused ctrl bits zero", v, 32'h101);
    check("R6 irq after enable write", {31'b0, irq}, 32'h1);
    busRead(DA, v); check("R8 data zero-extended", v, 32'h004);
    busWrite(CA, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    rawIn = 10'h2AA;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    busRead(DA, v); check("R9 read returns old value", v, 32'h004);
    peek(CA, 1'b0, v); check("R9 load wins over read", v, 32'h1);
    busRead(DA, v); check("R9 new value after tie", v, 32'h2AA);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_timing();
    t_glitch();
    t_ready_write();
    t_overrun();
    t_irq();
    t_data_write();
    t_select();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule